// File: doc/BRIEF.md
# Folded Decimate-by-Four Low-Pass FIR (I/Q pair)

This block low-pass filters a complex baseband stream and lowers its rate by four. It takes one I sample and one Q sample per handshake and returns one packed I/Q word for every fourth pair accepted. Each channel has its own tap history. One shared sequencer drives both channels through the same coefficient schedule. Only the outputs that survive decimation are ever computed. The impulse response is symmetric, so the two samples that share a coefficient are summed first, one bit wider, and the sum is multiplied once. The default filter has 187 taps and 94 coefficient slots, with the centre tap used alone.

The work is time-multiplexed. After every fourth accepted sample, the block spends one clock per coefficient slot doing a fold-multiply-accumulate on each channel. It then presents the scaled, saturated result and holds it until downstream takes it. While the block is computing, or while a result is waiting, it refuses new input. The clock must therefore run at least about 94/4 times faster than the sample rate for the default filter. Coefficients are set through a parameter. The default is a simple computed ramp, a placeholder for a designed low-pass set: for example, flat to 0.4 of the output rate, a stopband starting at 0.5 of the output rate, and about 100 dB of rejection.

Top module: `sym_decim_fir`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0, and every tap of both histories is zero, so the first outputs are computed as if all earlier samples were 0.
- R2: One output word is produced per DECIM (4) accepted samples. Output m (counting from 0) is the filter response at the accepted sample numbered DECIM*m+DECIM-1, counting from 0 since reset.
- R3: Each channel result is the sum over j=0..NTAPS-1 of h[j]*x[n-j], where x[n] is the newest accepted sample and h[j]=h[NTAPS-1-j]. The half set of coefficients sits in COEF_FLAT: slot k holds signed bits [k*COEF_W +: COEF_W] and serves taps k and NTAPS-1-k. Slot 0 is the outermost pair, and slot (NTAPS-1)/2 is the centre tap, counted once.
- R4: The full-precision sum is shifted right arithmetically by SHIFT bits. It is then saturated to the signed OUT_W range: anything above 2^(OUT_W-1)-1 becomes that value, and anything below -2^(OUT_W-1) becomes that value.
- R5: out_data carries the I result in bits [2*OUT_W-1:OUT_W] and the Q result in bits [OUT_W-1:0]. Each channel depends only on its own input stream.
- R6: out_valid rises exactly NPAIR=(NTAPS+1)/2 clock edges after the edge that accepted the DECIM-th sample of a group, and at no other time.
- R7: in_ready is 0 from the edge that accepts the DECIM-th sample until the result has been taken. in_valid and the input data presented during that time are ignored.
- R8: Once out_valid is 1, out_valid and out_data hold steady until an edge at which out_ready is 1. That edge consumes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Block can take an input pair this edge |
| in_i | input | IN_W | In-phase sample, two's complement |
| in_q | input | IN_W | Quadrature sample, two's complement |
| out_valid | output | 1 | Packed result is present |
| out_ready | input | 1 | Downstream takes the result this edge |
| out_data | output | 2*OUT_W | Packed result, I upper half, Q lower half |

## Verification
The bench builds the block with a 7-tap filter (four coefficient slots), DECIM of 4, 8-bit samples, 6-bit coefficients that include the most negative code, a 10-bit output and a shift of 3. At this size a sweep of single impulses across every tap position and decimation phase reads back each coefficient slot, including the unpaired centre. Full-scale random streams then push the sum past both saturation limits. Random and held-off downstream readiness exercises the stall, the hold of a pending word and the dropping of input offered while the block is busy. A reset part-way through the run shows that the histories are cleared.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;
  // Room reserved for the half coefficient set (slots * width must fit).
  localparam int COEF_SPACE = 4096;

  // Placeholder coefficient set: a positive ramp rising towards the centre,
  // peaking at half of the positive coefficient range.
  function automatic logic [COEF_SPACE-1:0] ramp_coefs(input int npair, input int coef_w);
    logic [COEF_SPACE-1:0] v;
    longint peak;
    longint val;
    v = '0;
    peak = longint'(1) <<< (coef_w - 2);
    for (int k = 0; k < npair; k++) begin
      val = ((longint'(k) + 1) * peak) / npair;
      for (int b = 0; b < coef_w; b++) begin
        v[k*coef_w + b] = val[b];
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/sdf_tap_line.sv
`timescale 1ns/1ps
module sdf_tap_line #(
  parameter int NTAPS = 187,
  parameter int W     = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [W-1:0]              din,
  output logic [NTAPS-1:0][W-1:0]   taps
);
  // taps[0] holds the newest accepted sample
  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        taps[t] <= '0;
      end else if (shift_en) begin
        if (t == 0) taps[t] <= din;
        else        taps[t] <= taps[(t > 0) ? t-1 : 0];
      end
    end
  end
endmodule

// File: rtl/sdf_seq_ctrl.sv
`timescale 1ns/1ps
module sdf_seq_ctrl #(
  parameter int DECIM = 4,
  parameter int NPAIR = 94,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             accept,
  output logic             start,
  output logic             step,
  output logic             last,
  output logic             out_valid,
  output logic [IDX_W-1:0] idx
);
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [PH_W-1:0] phase;
  logic            busy;

  assign in_ready = !busy && !out_valid;
  assign accept   = in_valid && in_ready;
  assign start    = accept && (phase == PH_W'(DECIM-1));
  assign step     = busy;
  assign last     = busy && (idx == IDX_W'(NPAIR-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (accept) begin
      phase <= start ? '0 : phase + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (last)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end
endmodule

// File: rtl/sdf_pair_mac.sv
`timescale 1ns/1ps
module sdf_pair_mac #(
  parameter int NTAPS  = 187,
  parameter int IN_W   = 24,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 32,
  parameter int SHIFT  = 11,
  parameter int IDX_W  = 7,
  parameter logic [sdf_pkg::COEF_SPACE-1:0] COEF_FLAT = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        step,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NTAPS-1:0][IN_W-1:0]  taps,
  output logic [OUT_W-1:0]            y_next
);
  localparam int NPAIR  = (NTAPS + 1) / 2;
  localparam int CENTRE = NPAIR - 1;
  localparam int PRE_W  = IN_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int TAP_W  = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam logic signed [ACC_W-1:0] OMAX = (ACC_W'(1) <<< (OUT_W-1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] OMIN = -(ACC_W'(1) <<< (OUT_W-1));

  // pre-add of the pair that shares one coefficient (one bit of growth)
  function automatic logic signed [PRE_W-1:0] fold(input logic [IN_W-1:0] a,
                                                   input logic [IN_W-1:0] b,
                                                   input logic use_b);
    logic signed [PRE_W-1:0] sa, sb;
    sa = {a[IN_W-1], a};
    sb = use_b ? {b[IN_W-1], b} : '0;
    return sa + sb;
  endfunction

  // arithmetic shift down, then clamp into the signed output range
  function automatic logic [OUT_W-1:0] clip(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] sh;
    sh = v >>> SHIFT;
    if (sh > OMAX)      return OMAX[OUT_W-1:0];
    else if (sh < OMIN) return OMIN[OUT_W-1:0];
    else                return sh[OUT_W-1:0];
  endfunction

  logic [TAP_W-1:0]         near_i, far_i;
  logic signed [PRE_W-1:0]  pre;
  logic signed [COEF_W-1:0] cf;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, acc_next;

  always_comb begin
    near_i   = TAP_W'(idx);
    far_i    = TAP_W'(NTAPS-1) - near_i;
    pre      = fold(taps[near_i], taps[far_i], idx != IDX_W'(CENTRE));
    cf       = signed'(COEF_FLAT[int'(idx)*COEF_W +: COEF_W]);
    prod     = PROD_W'(pre) * PROD_W'(cf);
    acc_next = acc + ACC_W'(prod);
    y_next   = clip(acc_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= acc_next;
  end
endmodule

// File: rtl/sym_decim_fir.sv
`timescale 1ns/1ps
module sym_decim_fir #(
  parameter int NTAPS  = 187,
  parameter int DECIM  = 4,
  parameter int IN_W   = 24,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 32,
  parameter int SHIFT  = 11,
  parameter logic [sdf_pkg::COEF_SPACE-1:0] COEF_FLAT =
    sdf_pkg::ramp_coefs((NTAPS + 1) / 2, COEF_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IN_W-1:0]    in_i,
  input  logic [IN_W-1:0]    in_q,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*OUT_W-1:0] out_data
);
  localparam int NPAIR = (NTAPS + 1) / 2;
  localparam int IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int NCH   = 2;  // channel 0 = I, channel 1 = Q

  // named internal events, also seen by the bound checker
  logic             accept, start, step, last;
  logic [IDX_W-1:0] idx;

  logic [NCH-1:0][IN_W-1:0]  ch_in;
  logic [NCH-1:0][OUT_W-1:0] ch_y;

  assign ch_in[0] = in_i;
  assign ch_in[1] = in_q;

  sdf_seq_ctrl #(.DECIM(DECIM), .NPAIR(NPAIR), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .accept(accept), .start(start), .step(step),
    .last(last), .out_valid(out_valid), .idx(idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NTAPS-1:0][IN_W-1:0] taps;

    sdf_tap_line #(.NTAPS(NTAPS), .W(IN_W)) u_line (
      .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(ch_in[c]), .taps(taps)
    );

    sdf_pair_mac #(
      .NTAPS(NTAPS), .IN_W(IN_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
      .OUT_W(OUT_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .COEF_FLAT(COEF_FLAT)
    ) u_mac (
      .clk(clk), .rst_n(rst_n), .clear(start), .step(step), .idx(idx),
      .taps(taps), .y_next(ch_y[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_data <= '0;
    else if (last) out_data <= {ch_y[0], ch_y[1]};
  end
endmodule

// File: rtl/sym_decim_fir_chk.sv
`timescale 1ns/1ps
module sym_decim_fir_chk #(
  parameter int DECIM = 4,
  parameter int NPAIR = 94,
  parameter int OUT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2*OUT_W-1:0] out_data,
  input logic               accept,
  input logic               start,
  input logic               step,
  input logic               last
);
  localparam int RUN_W = $clog2(NPAIR + 3) + 1;
  localparam int PH_W  = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [RUN_W-1:0] run;
  logic [PH_W-1:0]  acnt;

  // cycles since the group-closing accept, frozen once the word appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run <= '0;
    else if (start)                     run <= RUN_W'(1);
    else if (run != '0 && !out_valid)   run <= run + RUN_W'(1);
  end

  // independent count of accepts within a group
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acnt <= '0;
    else if (accept) acnt <= (acnt == PH_W'(DECIM-1)) ? '0 : acnt + PH_W'(1);
  end

  // R2
  group_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (accept && acnt == PH_W'(DECIM-1)));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (run == RUN_W'(NPAIR+1)));

  // R6
  rise_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(last));

  // R7
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !accept);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind sym_decim_fir sym_decim_fir_chk #(
  .DECIM(DECIM), .NPAIR((NTAPS + 1) / 2), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .accept(accept),
  .start(start), .step(step), .last(last)
);

// File: tb/sym_decim_fir_test.sv
`timescale 1ns/1ps
module sym_decim_fir_test;
  localparam int NT = 7;
  localparam int NP = (NT + 1) / 2;
  localparam int DEC = 4;
  localparam int IW = 8;
  localparam int CW = 6;
  localparam int AW = 24;
  localparam int OW = 10;
  localparam int SH = 3;
  // slots: 0 -> -32 (0x20), 1 -> 31, 2 -> -7 (0x39), 3 (centre) -> 13
  localparam logic [4*CW-1:0] CF = {6'd13, 6'h39, 6'd31, 6'h20};
  localparam int HALF [NP] = '{-32, 31, -7, 13};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IW-1:0] in_i = '0;
  logic [IW-1:0] in_q = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2*OW-1:0] out_data;

  always #2.5 clk = ~clk;

  sym_decim_fir #(
    .NTAPS(NT), .DECIM(DEC), .IN_W(IW), .COEF_W(CW), .ACC_W(AW),
    .OUT_W(OW), .SHIFT(SH), .COEF_FLAT(sdf_pkg::COEF_SPACE'(CF))
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int hi [NT];
  int hq [NT];
  int naccept, nout, cyc, start_cyc, bp_mode, sat_hi, sat_lo;
  bit ov_prev;
  int unsigned seed = 32'h1234_5678;
  logic [2*OW-1:0] expq [$];

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  function automatic int coef_of(int j);
    int k;
    k = (j < NT-1-j) ? j : NT-1-j;
    return HALF[k];
  endfunction

  // direct (unfolded) convolution, then shift and clamp
  function automatic logic [OW-1:0] model(input int h [NT], output int clamp);
    longint s;
    longint lim;
    s = 0;
    for (int j = 0; j < NT; j++) s += longint'(coef_of(j)) * h[j];
    s = s >>> SH;
    lim = longint'(1) <<< (OW-1);
    clamp = 0;
    if (s > lim - 1) begin s = lim - 1; clamp = 1; end
    if (s < -lim)    begin s = -lim;    clamp = -1; end
    return OW'(s);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int j = 0; j < NT; j++) begin hi[j] = 0; hq[j] = 0; end
    naccept = 0; nout = 0; ov_prev = 1'b0;
    expq.delete();
  endtask

  task automatic tick(input bit want, input int vi, input int vq, output bit got);
    int ci, cq;
    logic [OW-1:0] yi, yq;
    @(negedge clk);
    cyc++;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = rnd()[2];
      default: out_ready = 1'b0;
    endcase
    if (out_valid && !ov_prev) begin
      // R6: word appears NPAIR edges after the group-closing accept
      check(cyc - start_cyc == NP + 1, "R6", cyc - start_cyc, NP + 1);
    end
    ov_prev = out_valid;
    if (out_valid) begin
      // R7: blocked while a word is pending
      check(in_ready == 1'b0, "R7", in_ready, 0);
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2", out_data, 0);
      end else begin
        // R3 R4 R5: value, scaling and packing
        check(out_data == expq[0], "R3/R5", out_data, expq[0]);
        void'(expq.pop_front());
      end
      nout++;
    end
    in_valid = want;
    in_i = IW'(vi);
    in_q = IW'(vq);
    got = want && in_ready;
    if (got) begin
      for (int j = NT-1; j > 0; j--) begin hi[j] = hi[j-1]; hq[j] = hq[j-1]; end
      hi[0] = vi; hq[0] = vq;
      naccept++;
      if (naccept % DEC == 0) begin
        yi = model(hi, ci);
        yq = model(hq, cq);
        if (ci > 0 || cq > 0) sat_hi++;
        if (ci < 0 || cq < 0) sat_lo++;
        expq.push_back({yi, yq});
        start_cyc = cyc;
      end
    end
  endtask

  task automatic push(input int vi, input int vq);
    bit got;
    got = 1'b0;
    while (!got) tick(1'b1, vi, vq, got);
  endtask

  task automatic drain();
    bit got;
    int saved;
    saved = bp_mode;
    bp_mode = 0;
    for (int k = 0; k < NP + 6; k++) tick(1'b0, 0, 0, got);
    bp_mode = saved;
    // R2: one word per DEC accepts, none left over
    check(nout == naccept / DEC, "R2", nout, naccept / DEC);
    check(expq.size() == 0, "R2", expq.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    clear_model();
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(in_ready == 1'b1, "R1", in_ready, 1);
    check(out_valid == 1'b0, "R1", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    cyc = 0; start_cyc = 0; bp_mode = 0; sat_hi = 0; sat_lo = 0;
    clear_model();
    do_reset();

    // R1 R3: impulse sweep across every tap and phase; Q offset for R5 independence
    for (int p = 0; p < 3*DEC; p++) begin
      for (int n = 0; n < 3*DEC; n++) begin
        push((n == p) ? ((p % 2) ? -128 : 127) : 0,
             (n == (p + 5) % (3*DEC)) ? 100 : 0);
      end
    end
    drain();

    // R3: constant full-scale step
    for (int n = 0; n < 4*DEC; n++) push(127, -128);
    drain();

    // R7 R8: word held while downstream stalls; offered input dropped
    bp_mode = 2;
    for (int n = 0; n < DEC; n++) push(40 + n, -3 * n);
    while (!out_valid) tick(1'b0, 0, 0, got);
    for (int k = 0; k < 5; k++) begin
      tick(1'b1, 99, -99, got);
      check(got == 1'b0, "R7", got, 0);
    end
    bp_mode = 0;
    for (int n = 0; n < 2*DEC; n++) push(n * 7 - 20, 50 - n);
    drain();

    // R4 R8: full-scale random signs under random backpressure
    bp_mode = 1;
    for (int n = 0; n < 80 * DEC; n++) begin
      push(rnd()[0] ? 127 : -128, rnd()[1] ? 127 : -128);
    end
    drain();
    check(sat_hi > 0, "R4", sat_hi, 1);
    check(sat_lo > 0, "R4", sat_lo, 1);

    // R3: mid-range random values under random backpressure
    for (int n = 0; n < 60 * DEC; n++) begin
      push((rnd() % 256) - 128, (rnd() % 256) - 128);
    end
    drain();

    // R1: reset mid-stream clears the histories
    bp_mode = 0;
    for (int n = 0; n < DEC + 2; n++) push(120, -120);
    do_reset();
    push(0, 0); push(0, 0); push(0, 0); push(64, -64);
    push(0, 0); push(0, 0); push(0, 0); push(0, 0);
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule